// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a memory-mapped watchdog for a system controller. Software writes a control word that sets a 16-bit reload value, turns the watchdog on, chooses whether an expiry requests a system reset or raises an interrupt, and can slow the count by a fixed division of 2048. Once running, a 16-bit down-counter decrements on every count tick. Software must service the watchdog before the counter runs out. Servicing means writing a two-word key in strict order to the service register, and only a complete key reloads the counter. A debug-halt input can pause the count, but only when the freeze bit in the control word allows it. The bus-monitor enable and its 8-bit timeout are stored and read back for a neighbouring block; nothing here acts on them.

The bus is a simple single-cycle register port. `bus_addr` is a word-aligned byte address, and bits [3:2] select the register: 0x4 is the control word, 0x8 is the count (read only), and 0xC is the word that holds the big-endian 16-bit service halfword at 0xE, which appears on `bus_wdata[15:0]`. Reads are combinational. Address 0x0 and anything not mapped read as zero.

There are two state machines. The key checker has the states KEY_IDLE and KEY_ARMED. A service write of 0x556C moves it from KEY_IDLE to KEY_ARMED, or keeps it in KEY_ARMED. A write of 0xAA39 in KEY_ARMED returns it to KEY_IDLE and reloads the counter. Any other service write returns it to KEY_IDLE. The count engine has the states CNT_OFF, CNT_RUN and CNT_HOLD. It is in CNT_OFF while the watchdog is disabled, in CNT_HOLD while it is enabled with both freeze and debug-halt set, and in CNT_RUN otherwise while enabled.

Top module: `wdk_top`

## Requirements
- R1: The control word at 0x4 holds reload value [31:16], bus-monitor timeout [15:8], bus-monitor enable [7], freeze [3], enable [2], action select [1] (1 = reset, 0 = interrupt) and prescale enable [0], and each field reads back as written.
- R2: After reset the control word reads 0xFFFF0000 and both outputs are low. Control bits [6:4], address 0x0 and the service location always read as zero.
- R3: Once the enable bit is 1, it stays at 1 until reset. A control write with bit 2 clear leaves it set, and counting continues.
- R4: With prescale off, the count register (0x8, value in [15:0]) decrements by one on every clock edge after the enable write. With reload value N it reads 1 after N-1 edges.
- R5: With prescale on, the counter decrements once every 2048 clocks, the first time on the 2048th edge after enabling.
- R6: In reset mode, the edge on which the counter would pass from 1 to 0 makes `rst_req` high for exactly one cycle and reloads the counter with N.
- R7: In interrupt mode, expiry sets `irq_req`, which then stays high until reset. The counter reloads and `rst_req` stays low.
- R8: A service write of 0x556C followed directly by a service write of 0xAA39 reloads the counter with the reload value on the second write's edge.
- R9: A service word other than 0x556C, written after 0x556C, cancels the sequence. 0xAA39 with no 0x556C directly before it does nothing. A repeated 0x556C keeps the sequence armed.
- R10: With freeze and debug-halt both high, the counter holds its value. With debug-halt high and freeze clear, it keeps counting.
- R11: Writes to the count register are ignored, and the count keeps decrementing normally.
- R12: While disabled, the counter follows the reload value one edge later and neither output is ever asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Word-aligned byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| dbg_halt | input | 1 | Debug halt, pauses counting when freeze is set |
| rst_req | output | 1 | One-cycle system reset request on expiry |
| irq_req | output | 1 | Sticky interrupt request on expiry |

## Verification
The assertions assume that `bus_wr` is a clean one-cycle strobe per access, with address and data stable at the edge it is sampled on. They also assume that `dbg_halt` changes only between edges. The bench drives every input on the falling edge and holds each write for a single rising edge. Each scenario starts from a fresh reset, so the sticky interrupt and the locked enable never carry over from one scenario into the next. The bench sets the reload value with the enable bit clear before it enables the watchdog, so the counter starts from a known value.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    localparam int TMO_W = 16;

    localparam logic [15:0] KEY_FIRST  = 16'h556C;
    localparam logic [15:0] KEY_SECOND = 16'hAA39;

    localparam logic [1:0] SLOT_CTRL  = 2'd1;
    localparam logic [1:0] SLOT_COUNT = 2'd2;
    localparam logic [1:0] SLOT_SVC   = 2'd3;

    typedef enum logic {
        KEY_IDLE,
        KEY_ARMED
    } key_state_t;

    typedef enum logic [1:0] {
        CNT_OFF,
        CNT_RUN,
        CNT_HOLD
    } cnt_state_t;

    typedef struct packed {
        logic [TMO_W-1:0] tmo;
        logic [7:0]       bmt;
        logic             bme;
        logic             frz;
        logic             en;
        logic             rsel;
        logic             psc;
    } ctrl_t;

endpackage

// File: rtl/wdk_ctrl_regs.sv
module wdk_ctrl_regs
    import wdk_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [TMO_W-1:0] cnt_i,
    output ctrl_t            ctrl_o,
    output logic [DW-1:0]    rdata_o
);

    ctrl_t      ctrl_q;
    logic [1:0] slot;
    logic       ctrl_wr;

    assign slot    = addr_i[3:2];
    assign ctrl_wr = wr_i && (slot == SLOT_CTRL);

    logic unused_bits;
    assign unused_bits = &{1'b0, addr_i[1:0], wdata_i[6:4]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            ctrl_q.tmo <= '1;
        end else if (ctrl_wr) begin
            ctrl_q.tmo  <= wdata_i[31:16];
            ctrl_q.bmt  <= wdata_i[15:8];
            ctrl_q.bme  <= wdata_i[7];
            ctrl_q.frz  <= wdata_i[3];
            ctrl_q.en   <= ctrl_q.en | wdata_i[2];
            ctrl_q.rsel <= wdata_i[1];
            ctrl_q.psc  <= wdata_i[0];
        end
    end

    always_comb begin
        rdata_o = '0;
        case (slot)
            SLOT_CTRL:  rdata_o = {ctrl_q.tmo, ctrl_q.bmt, ctrl_q.bme, 3'b000,
                                   ctrl_q.frz, ctrl_q.en, ctrl_q.rsel, ctrl_q.psc};
            SLOT_COUNT: rdata_o = {{(DW-TMO_W){1'b0}}, cnt_i};
            default:    rdata_o = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;

    // R3
    en_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.en |=> ctrl_q.en);

endmodule

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
    import wdk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [15:0] data_i,
    output logic        reload_o
);

    key_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        reload_o = 1'b0;
        if (wr_i) begin
            unique case (state_q)
                KEY_IDLE: begin
                    if (data_i == KEY_FIRST) state_d = KEY_ARMED;
                end
                KEY_ARMED: begin
                    if (data_i == KEY_SECOND) begin
                        reload_o = 1'b1;
                        state_d  = KEY_IDLE;
                    end else if (data_i == KEY_FIRST) begin
                        state_d = KEY_ARMED;
                    end else begin
                        state_d = KEY_IDLE;
                    end
                end
                default: state_d = KEY_IDLE;
            endcase
        end
    end

    // R8
    key_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |=> state_q == KEY_IDLE);

endmodule

// File: rtl/wdk_countdown.sv
module wdk_countdown
    import wdk_pkg::*;
#(
    parameter int TW       = TMO_W,
    parameter int PRESCALE = 2048
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          psc_i,
    input  logic          rsel_i,
    input  logic          frz_i,
    input  logic          halt_i,
    input  logic [TW-1:0] tmo_i,
    input  logic          reload_i,
    output logic [TW-1:0] cnt_o,
    output logic          rst_req_o,
    output logic          irq_o
);

    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

    cnt_state_t    mode;
    logic [TW-1:0] cnt_q;
    logic [PW-1:0] pre_q;
    logic          rst_q;
    logic          irq_q;
    logic          tick;
    logic          expire;

    always_comb begin
        if (!en_i)                mode = CNT_OFF;
        else if (frz_i && halt_i) mode = CNT_HOLD;
        else                      mode = CNT_RUN;
    end

    assign tick   = psc_i ? (pre_q == PRE_LAST) : 1'b1;
    assign expire = tick && (cnt_q <= TW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
            pre_q <= '0;
            rst_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            rst_q <= 1'b0;
            unique case (mode)
                CNT_OFF: begin
                    cnt_q <= tmo_i;
                    pre_q <= '0;
                end
                CNT_HOLD: begin
                    if (reload_i) begin
                        cnt_q <= tmo_i;
                        pre_q <= '0;
                    end
                end
                CNT_RUN: begin
                    if (reload_i) begin
                        cnt_q <= tmo_i;
                        pre_q <= '0;
                    end else begin
                        if (psc_i) pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
                        else       pre_q <= '0;
                        if (expire) begin
                            cnt_q <= tmo_i;
                            if (rsel_i) rst_q <= 1'b1;
                            else        irq_q <= 1'b1;
                        end else if (tick) begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                default: cnt_q <= tmo_i;
            endcase
        end
    end

    assign cnt_o     = cnt_q;
    assign rst_req_o = rst_q;
    assign irq_o     = irq_q;

    // R10
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && frz_i && halt_i && !reload_i) |=> $stable(cnt_q));

    // R12
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !rst_req_o);

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> irq_o);

    // R6
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> !$rose(irq_o));

endmodule

// File: rtl/wdk_top.sv
module wdk_top
    import wdk_pkg::*;
#(
    parameter int PRESCALE = 2048
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        dbg_halt,
    output logic        rst_req,
    output logic        irq_req
);

    ctrl_t            ctrl;
    logic [TMO_W-1:0] cnt;
    logic             svc_wr;
    logic             reload;

    assign svc_wr = bus_wr && (bus_addr[3:2] == SLOT_SVC);

    wdk_ctrl_regs #(.AW(4), .DW(32)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .cnt_i   (cnt),
        .ctrl_o  (ctrl),
        .rdata_o (bus_rdata)
    );

    wdk_keyseq u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (svc_wr),
        .data_i   (bus_wdata[15:0]),
        .reload_o (reload)
    );

    wdk_countdown #(.TW(TMO_W), .PRESCALE(PRESCALE)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (ctrl.en),
        .psc_i     (ctrl.psc),
        .rsel_i    (ctrl.rsel),
        .frz_i     (ctrl.frz),
        .halt_i    (dbg_halt),
        .tmo_i     (ctrl.tmo),
        .reload_i  (reload),
        .cnt_o     (cnt),
        .rst_req_o (rst_req),
        .irq_o     (irq_req)
    );

endmodule

// File: tb/wdk_top_test.sv
`timescale 1ns/1ps
module wdk_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        dbg_halt;
    logic        rst_req;
    logic        irq_req;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    wdk_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dbg_halt  (dbg_halt),
        .rst_req   (rst_req),
        .irq_req   (irq_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = '0; dbg_halt = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        rd(4'h4, v); check("R2 ctrl reset", v, 32'hFFFF0000);
        rd(4'h0, v); check("R2 addr0 zero", v, 32'h0);
        rd(4'hC, v); check("R2 service reads zero", v, 32'h0);
        rd(4'h8, v); check("R12 count at reset", v, 32'h0000FFFF);
        check("R2 rst_req low", {31'b0, rst_req}, 32'h0);
        check("R2 irq_req low", {31'b0, irq_req}, 32'h0);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        do_reset();
        wr(4'h4, 32'hABCD5A8B);
        rd(4'h4, v); check("R1 field readback", v, 32'hABCD5A8B);
        wr(4'h4, 32'h000000F0);
        rd(4'h4, v); check("R2 bits 6:4 read zero", v, 32'h00000080);
        rd(4'h8, v); check("R12 count follows old reload", v, 32'h0000ABCD);
        wait_edges(1);
        rd(4'h8, v); check("R12 count follows reload", v, 32'h0);
    endtask

    task automatic t_disabled_quiet();
        logic [31:0] v;
        do_reset();
        wr(4'h4, 32'h00010002);
        wait_edges(10);
        check("R12 no rst while off", {31'b0, rst_req}, 32'h0);
        check("R12 no irq while off", {31'b0, irq_req}, 32'h0);
        rd(4'h8, v); check("R12 count holds reload", v, 32'h1);
    endtask

    task automatic t_reset_mode();
        logic [31:0] v;
        do_reset();
        wr(4'h4, 32'h00060002);
        wr(4'h4, 32'h00060006);
        rd(4'h8, v); check("R4 start value", v, 32'h6);
        wait_edges(5);
        rd(4'h8, v); check("R4 count down to 1", v, 32'h1);
        check("R6 no rst before expiry", {31'b0, rst_req}, 32'h0);
        wait_edges(1);
        check("R6 rst pulse", {31'b0, rst_req}, 32'h1);
        rd(4'h8, v); check("R6 reload on expiry", v, 32'h6);
        wait_edges(1);
        check("R6 pulse one cycle", {31'b0, rst_req}, 32'h0);
        check("R6 no irq in reset mode", {31'b0, irq_req}, 32'h0);
        rd(4'h8, v); check("R6 counting resumes", v, 32'h5);
        wr(4'h4, 32'h00060002);
        rd(4'h4, v); check("R3 enable locked", v, 32'h00060006);
        rd(4'h8, v); check("R3 still counting", v, 32'h4);
        wait_edges(1);
        rd(4'h8, v); check("R3 counting after clear attempt", v, 32'h3);
    endtask

    task automatic t_irq_mode();
        logic [31:0] v;
        do_reset();
        wr(4'h4, 32'h00040000);
        wr(4'h4, 32'h00040004);
        wait_edges(3);
        check("R7 no irq yet", {31'b0, irq_req}, 32'h0);
        wait_edges(1);
        check("R7 irq set", {31'b0, irq_req}, 32'h1);
        rd(4'h8, v); check("R7 reload after expiry", v, 32'h4);
        wait_edges(4);
        check("R7 irq sticky", {31'b0, irq_req}, 32'h1);
        check("R7 no rst in irq mode", {31'b0, rst_req}, 32'h0);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        do_reset();
        wr(4'h4, 32'h00020001);
        wr(4'h4, 32'h00020005);
        wait_edges(2047);
        rd(4'h8, v); check("R5 no step before 2048", v, 32'h2);
        wait_edges(1);
        rd(4'h8, v); check("R5 step at 2048", v, 32'h1);
        wait_edges(2047);
        check("R5 no expiry early", {31'b0, irq_req}, 32'h0);
        wait_edges(1);
        check("R5 expiry at 4096", {31'b0, irq_req}, 32'h1);
    endtask

    task automatic t_service();
        logic [31:0] v;
        do_reset();
        wr(4'h4, 32'h00140000);
        wr(4'h4, 32'h00140004);
        wait_edges(5);
        rd(4'h8, v); check("R4 count 15", v, 32'd15);
        wr(4'hC, 32'h0000556C);
        wr(4'hC, 32'h0000AA39);
        rd(4'h8, v); check("R8 key reload", v, 32'd20);
        wr(4'hC, 32'h0000556C);
        wr(4'hC, 32'h00001234);
        wr(4'hC, 32'h0000AA39);
        rd(4'h8, v); check("R9 wrong word cancels", v, 32'd17);
        wr(4'hC, 32'h0000AA39);
        rd(4'h8, v); check("R9 lone second key ignored", v, 32'd16);
        wr(4'hC, 32'h0000556C);
        wr(4'hC, 32'h0000556C);
        wr(4'hC, 32'h0000AA39);
        rd(4'h8, v); check("R9 repeat first key stays armed", v, 32'd20);
    endtask

    task automatic t_freeze();
        logic [31:0] v;
        do_reset();
        wr(4'h4, 32'h000A0008);
        wr(4'h4, 32'h000A000C);
        wait_edges(3);
        rd(4'h8, v); check("R10 before halt", v, 32'd7);
        dbg_halt = 1'b1;
        wait_edges(5);
        rd(4'h8, v); check("R10 frozen", v, 32'd7);
        dbg_halt = 1'b0;
        wait_edges(2);
        rd(4'h8, v); check("R10 resumes", v, 32'd5);
        wr(4'h4, 32'h000A0004);
        dbg_halt = 1'b1;
        wait_edges(2);
        rd(4'h8, v); check("R10 halt without freeze counts", v, 32'd2);
        dbg_halt = 1'b0;
    endtask

    task automatic t_count_readonly();
        logic [31:0] v;
        do_reset();
        wr(4'h4, 32'h00100000);
        wr(4'h4, 32'h00100004);
        wr(4'h8, 32'h00000003);
        rd(4'h8, v); check("R11 count write ignored", v, 32'd15);
        wait_edges(1);
        rd(4'h8, v); check("R11 count continues", v, 32'd14);
        rd(4'h4, v); check("R11 ctrl untouched", v, 32'h00100004);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_fields();
        t_disabled_quiet();
        t_reset_mode();
        t_irq_mode();
        t_prescale();
        t_service();
        t_freeze();
        t_count_readonly();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule